// File: doc/BRIEF.md
# Coherence Response Combiner

This block sits beside one arbitration node and gathers three kinds of snoop-time response from the devices attached to it: a request to halt grant-making (stop), a report that a line is held in more than one cache (shared), and a claim of ownership (owner). Every line is active-low. Stop and shared are reduced inside the block. The owner line reaches the block already merged by the board wiring and is only registered. Each result is registered and driven out on a broadcast line that goes to every node in the system, this one included.

On the return side the block takes the broadcast lines coming back from all nodes. It reduces the stop and shared sets into one asserted-if-any value each and registers them. It registers the single returned owner line unchanged. These three registered values go back to the local devices. The send side and the return side are separate register stages, so one transaction can be broadcast while the transaction one stage ahead is being reduced, both in the same clock cycle.

Top module: `cresp_combiner`

## Requirements
- R1: While rst_n is low, all six outputs (bcast_stop_n, bcast_shared_n, bcast_owner_n, ret_stop_n, ret_shared_n, ret_owner_n) are high (deasserted). Reset is asynchronous.
- R2: After each rising clock edge, bcast_stop_n is low exactly when at least one bit of dev_stop_n was low at that edge, and high otherwise.
- R3: After each rising clock edge, bcast_shared_n is low exactly when at least one bit of dev_shared_n was low at that edge.
- R4: After each rising clock edge, bcast_owner_n equals the value dev_owner_n had at that edge. It is a one-cycle delay with no reduction.
- R5: After each rising clock edge, ret_stop_n is low exactly when at least one bit of node_stop_n was low at that edge.
- R6: After each rising clock edge, ret_shared_n is low exactly when at least one bit of node_shared_n was low at that edge.
- R7: After each rising clock edge, ret_owner_n equals the value node_owner_n had at that edge.
- R8: The send and return sides do not affect each other within a cycle. Broadcast outputs depend only on dev_* inputs, and returned outputs depend only on node_* inputs, even when both sides change in the same cycle.
- R9: A single low bit at any one position of dev_stop_n or dev_shared_n, with all other bits high, is enough to drive the matching broadcast low after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_stop_n | input | NUM_DEV | Stop request per local device, active low |
| dev_shared_n | input | NUM_DEV | Shared report per local device, active low |
| dev_owner_n | input | 1 | Owner claim from the local devices, already merged by wiring, active low |
| bcast_stop_n | output | 1 | Registered stop broadcast to all nodes |
| bcast_shared_n | output | 1 | Registered shared broadcast to all nodes |
| bcast_owner_n | output | 1 | Registered owner broadcast to all nodes |
| node_stop_n | input | NUM_NODE | Stop broadcasts returned from every node |
| node_shared_n | input | NUM_NODE | Shared broadcasts returned from every node |
| node_owner_n | input | 1 | Owner line returned from the system, merged by wiring |
| ret_stop_n | output | 1 | Registered system-wide stop to the local devices |
| ret_shared_n | output | 1 | Registered system-wide shared to the local devices |
| ret_owner_n | output | 1 | Registered owner value to the local devices |

## Verification
The two functions that coincide are the send-side reduction of a new transaction and the return-side reduction of the previous one. Both are register stages updated on the same clock edge. The bench closes the loop itself: node input 0 carries this block's own broadcast from the previous cycle, the other node inputs carry random values from modelled peers, and the owner return is the AND of the block's own broadcast with a modelled peer line. As a result, every random cycle has fresh local responses entering while the prior broadcast is being reduced. Directed cycles drive all local lines asserted against all-deasserted node lines, and the reverse. Each output is compared against a reduction of the inputs the bench applied one edge earlier, so any leakage between the two sides shows up as a mismatch.

// File: rtl/cresp_pkg.sv
package cresp_pkg;

    typedef struct packed {
        logic stop_n;
        logic shared_n;
        logic owner_n;
    } resp_t;

    localparam resp_t RESP_IDLE = '{stop_n: 1'b1, shared_n: 1'b1, owner_n: 1'b1};

    localparam int NUM_REDUCED = 2;

endpackage

// File: rtl/cresp_reduce.sv
module cresp_reduce #(
    parameter int W = 8
) (
    input  logic [W-1:0] in_n,
    output logic         any_n
);
    // Active-low OR: result asserted (low) if any input is low.
    always_comb begin
        any_n = 1'b1;
        for (int i = 0; i < W; i++) begin
            if (!in_n[i]) any_n = 1'b0;
        end
    end
endmodule

// File: rtl/cresp_stage.sv
module cresp_stage
    import cresp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stop_n,
    input  logic [W-1:0] shared_n,
    input  logic         owner_n,
    output resp_t        out_q
);
    logic [NUM_REDUCED-1:0][W-1:0] bank;
    logic [NUM_REDUCED-1:0]        any_n;

    assign bank[0] = stop_n;
    assign bank[1] = shared_n;

    for (genvar g = 0; g < NUM_REDUCED; g++) begin : g_red
        cresp_reduce #(.W(W)) u_red (
            .in_n  (bank[g]),
            .any_n (any_n[g])
        );
    end

    resp_t stage_d, stage_q;

    always_comb begin
        stage_d          = stage_q;
        stage_d.stop_n   = any_n[0];
        stage_d.shared_n = any_n[1];
        stage_d.owner_n  = owner_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= RESP_IDLE;
        else        stage_q <= stage_d;
    end

    assign out_q = stage_q;
endmodule

// File: rtl/cresp_combiner.sv
module cresp_combiner
    import cresp_pkg::*;
#(
    parameter int NUM_DEV  = 8,
    parameter int NUM_NODE = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_DEV-1:0]  dev_stop_n,
    input  logic [NUM_DEV-1:0]  dev_shared_n,
    input  logic                dev_owner_n,
    output logic                bcast_stop_n,
    output logic                bcast_shared_n,
    output logic                bcast_owner_n,
    input  logic [NUM_NODE-1:0] node_stop_n,
    input  logic [NUM_NODE-1:0] node_shared_n,
    input  logic                node_owner_n,
    output logic                ret_stop_n,
    output logic                ret_shared_n,
    output logic                ret_owner_n
);
    resp_t send_q, ret_q;

    // Outbound stage: local devices -> broadcast to every node
    cresp_stage #(.W(NUM_DEV)) u_send (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_n   (dev_stop_n),
        .shared_n (dev_shared_n),
        .owner_n  (dev_owner_n),
        .out_q    (send_q)
    );

    // Return stage: all node broadcasts -> local devices
    cresp_stage #(.W(NUM_NODE)) u_ret (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_n   (node_stop_n),
        .shared_n (node_shared_n),
        .owner_n  (node_owner_n),
        .out_q    (ret_q)
    );

    assign bcast_stop_n   = send_q.stop_n;
    assign bcast_shared_n = send_q.shared_n;
    assign bcast_owner_n  = send_q.owner_n;
    assign ret_stop_n     = ret_q.stop_n;
    assign ret_shared_n   = ret_q.shared_n;
    assign ret_owner_n    = ret_q.owner_n;
endmodule

// File: rtl/cresp_combiner_chk.sv
module cresp_combiner_chk #(
    parameter int NUM_DEV  = 8,
    parameter int NUM_NODE = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_DEV-1:0]  dev_stop_n,
    input logic [NUM_DEV-1:0]  dev_shared_n,
    input logic                dev_owner_n,
    input logic                bcast_stop_n,
    input logic                bcast_shared_n,
    input logic                bcast_owner_n,
    input logic [NUM_NODE-1:0] node_stop_n,
    input logic [NUM_NODE-1:0] node_shared_n,
    input logic                node_owner_n,
    input logic                ret_stop_n,
    input logic                ret_shared_n,
    input logic                ret_owner_n
);
    // R1
    reset_idle_chk: assert property (@(negedge clk)
        !rst_n |-> (bcast_stop_n && bcast_shared_n && bcast_owner_n &&
                    ret_stop_n && ret_shared_n && ret_owner_n));

    // R2
    bcast_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bcast_stop_n == ($past(dev_stop_n) == '1)));

    // R3
    bcast_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bcast_shared_n == ($past(dev_shared_n) == '1)));

    // R4
    bcast_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bcast_owner_n == $past(dev_owner_n)));

    // R5
    ret_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ret_stop_n == ($past(node_stop_n) == '1)));

    // R6
    ret_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ret_shared_n == ($past(node_shared_n) == '1)));

    // R7
    ret_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ret_owner_n == $past(node_owner_n)));

    // R9
    single_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($countones(~$past(dev_stop_n)) == 1)) |-> !bcast_stop_n);
endmodule

bind cresp_combiner cresp_combiner_chk #(
    .NUM_DEV  (NUM_DEV),
    .NUM_NODE (NUM_NODE)
) i_cresp_combiner_chk (.*);

// File: tb/test_cresp_combiner.sv
module test_cresp_combiner;
    localparam int ND = 8;
    localparam int NN = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [ND-1:0] dev_stop_n, dev_shared_n;
    logic          dev_owner_n;
    logic [NN-1:0] node_stop_n, node_shared_n;
    logic          node_owner_n;
    logic          bcast_stop_n, bcast_shared_n, bcast_owner_n;
    logic          ret_stop_n, ret_shared_n, ret_owner_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit armed  = 1'b0;

    logic [ND-1:0] p_ds, p_dsh;
    logic          p_dow;
    logic [NN-1:0] p_ns, p_nsh;
    logic          p_now;

    always #5 clk = ~clk;

    cresp_combiner #(.NUM_DEV(ND), .NUM_NODE(NN)) i_cresp_combiner (
        .clk(clk), .rst_n(rst_n),
        .dev_stop_n(dev_stop_n), .dev_shared_n(dev_shared_n), .dev_owner_n(dev_owner_n),
        .bcast_stop_n(bcast_stop_n), .bcast_shared_n(bcast_shared_n), .bcast_owner_n(bcast_owner_n),
        .node_stop_n(node_stop_n), .node_shared_n(node_shared_n), .node_owner_n(node_owner_n),
        .ret_stop_n(ret_stop_n), .ret_shared_n(ret_shared_n), .ret_owner_n(ret_owner_n)
    );

    // Expected active-low OR: low when any line is asserted.
    function automatic logic any_low8(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i] == 1'b0) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [7:0] rnd_lines();
        logic [7:0] v = '1;
        for (int i = 0; i < 8; i++) if ($urandom % 12 == 0) v[i] = 1'b0;
        return v;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: check outputs from last drive, then drive new values.
    // Node line 0 is this node's own broadcast; owner return is own AND peer.
    task automatic step(input logic [ND-1:0] ds, input logic [ND-1:0] dsh, input logic dow,
                        input logic [NN-2:0] ps, input logic [NN-2:0] psh, input logic pow);
        @(negedge clk);
        if (armed) begin
            chk("R2", bcast_stop_n,   any_low8(p_ds));
            chk("R3", bcast_shared_n, any_low8(p_dsh));
            chk("R4", bcast_owner_n,  p_dow);
            chk("R5", ret_stop_n,     any_low8(p_ns));
            chk("R6", ret_shared_n,   any_low8(p_nsh));
            chk("R7", ret_owner_n,    p_now);
            if ($countones(~p_ds) == 1)  chk("R9", bcast_stop_n, 1'b0);
            if ($countones(~p_dsh) == 1) chk("R9", bcast_shared_n, 1'b0);
        end
        dev_stop_n    = ds;
        dev_shared_n  = dsh;
        dev_owner_n   = dow;
        node_stop_n   = {ps, bcast_stop_n};
        node_shared_n = {psh, bcast_shared_n};
        node_owner_n  = bcast_owner_n & pow;
        p_ds = dev_stop_n;  p_dsh = dev_shared_n;  p_dow = dev_owner_n;
        p_ns = node_stop_n; p_nsh = node_shared_n; p_now = node_owner_n;
        armed = 1'b1;
    endtask

    task automatic check_reset_idle();
        chk("R1", bcast_stop_n, 1'b1);   chk("R1", bcast_shared_n, 1'b1);
        chk("R1", bcast_owner_n, 1'b1);  chk("R1", ret_stop_n, 1'b1);
        chk("R1", ret_shared_n, 1'b1);   chk("R1", ret_owner_n, 1'b1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        rst_n = 1'b0;
        dev_stop_n = 8'h00; dev_shared_n = 8'h00; dev_owner_n = 1'b0;
        node_stop_n = 8'h00; node_shared_n = 8'h00; node_owner_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: asserted inputs must not reach outputs under reset
        check_reset_idle();

        @(negedge clk);
        rst_n = 1'b1;
        step('1, '1, 1'b1, '1, '1, 1'b1);
        step('1, '1, 1'b1, '1, '1, 1'b1);

        // R9: each single device position alone
        for (int i = 0; i < ND; i++) begin
            step(~(8'h01 << i), ~(8'h80 >> i), i[0], '1, '1, 1'b1);
        end
        // R5/R6: each single peer node position alone
        for (int i = 0; i < NN - 1; i++) begin
            step('1, '1, 1'b1, ~(7'h01 << i), ~(7'h40 >> i), 1'b1);
        end

        // R8: local side fully asserted while peers deasserted, then the reverse
        step('0, '0, 1'b0, '1, '1, 1'b1);
        @(negedge clk);
        chk("R8", bcast_stop_n, 1'b0);
        chk("R8", ret_stop_n,   1'b1);
        step('1, '1, 1'b1, '0, '0, 1'b0);
        @(negedge clk);
        chk("R8", bcast_shared_n, 1'b1);
        chk("R8", ret_shared_n,   1'b0);
        chk("R8", ret_owner_n,    1'b0);

        // Random traffic with the broadcast looped back
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a, b, c, d;
            a = rnd_lines(); b = rnd_lines(); c = rnd_lines(); d = rnd_lines();
            step(a, b, ($urandom % 6) != 0, c[NN-2:0], d[NN-2:0], ($urandom % 6) != 0);
        end

        // R1: reset mid-run with asserted inputs
        step('0, '0, 1'b0, '0, '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        armed = 1'b0;
        @(negedge clk);
        check_reset_idle();
        rst_n = 1'b1;
        step('1, 8'hfe, 1'b0, '1, '1, 1'b1);
        step('1, '1, 1'b1, '1, '1, 1'b1);
        step('1, '1, 1'b1, '1, '1, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule